// File: doc/BRIEF.md
# Multi-channel looping pattern generator

This block plays back stored word sequences on several parallel output channels at once. Each channel owns a pattern memory of 128 words, each 28 bits wide. A single address sequencer runs freely and steps through the table one index per clock, wrapping from the last entry to the first with no idle cycle. Every channel reads the same index from its own memory, so all outputs stay cycle-aligned. One parallel word per channel appears on each clock.

A host loads the tables and reads them back through a second memory port. The host address carries a channel select above a 7-bit word index. Host accesses share the playback clock but never pause the sequencer. A new word takes effect the next time playback reaches its address. A narrow mode drives only the low 21 bits of every channel word, for 21-bit links. A static select picks either the local 50 MHz clock or an external clock as the block clock. The select is changed only while reset is held.

Top module: `pattern_player`

## Requirements
- R1: A host write with hostWr=1 stores hostWrData in the channel given by hostAddr[9:7] at the word index hostAddr[6:0]. That word appears on channel c's output (chanData[28c+27:28c]) whenever playIndex equals that index, from the next pass onward.
- R2: After the first output cycle, playIndex rises by one on every clock and wraps from 127 to 0 with no repeated or skipped index. Each channel outputs the word stored at playIndex.
- R3: All channels present the word of the same index on the same clock cycle.
- R4: A cycle with hostRd=1 gives hostRdValid=1 on the next cycle, with hostRdData equal to the full 28-bit stored word. hostRdValid is 0 in a cycle that follows no read.
- R5: Channel selects 4 to 7 are unimplemented. Writes to them change no stored word, including the word at the same index of any other channel. Reads of them return zero.
- R6: While reset is low and until the first clock edge after its release, chanData is all zero and playIndex is 0. After the first edge, every channel shows its word 0 with playIndex 0, and playback then advances.
- R7: With narrowMode=1, bits 27:21 of every channel are driven 0 and bits 20:0 carry the stored word. Readback still returns all 28 bits.
- R8: With clkSel=0 the block runs from clkLocal. With clkSel=1 it runs from clkExt and keeps playing with clkLocal stopped. clkSel changes only during reset.
- R9: Host writes and reads in any cycle leave the sequencer stepping one index per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkLocal | input | 1 | Local 50 MHz clock |
| clkExt | input | 1 | External clock alternative |
| clkSel | input | 1 | 0 selects clkLocal, 1 selects clkExt; static outside reset |
| rst_n | input | 1 | Active-low asynchronous reset |
| narrowMode | input | 1 | 1 drives only the low 21 bits of each word |
| hostAddr | input | 10 | Channel select [9:7], word index [6:0] |
| hostWrData | input | 28 | Word to store |
| hostWr | input | 1 | Write strobe |
| hostRd | input | 1 | Read strobe |
| hostRdData | output | 28 | Readback word, one cycle after hostRd |
| hostRdValid | output | 1 | Marks hostRdData as valid |
| chanData | output | 112 | Four 28-bit channel words, channel 0 in the low bits |
| playIndex | output | 7 | Table index of the words currently on chanData |

## Verification
The assertions check on every cycle that playIndex steps by one and wraps from 127 to 0, that the outputs stay zero before the first edge after reset, and that narrow mode clears the upper bits. They also check that each read is answered one cycle later and that reads of an unimplemented channel return zero. Only the bench scenarios can show that the channel contents match what the host loaded, that all channels line up on the same index, and that a write during playback shows up on a later pass. The same holds for a write to an unimplemented channel leaving the other memories untouched, and for playback continuing from the external clock when the local clock stops.

// File: rtl/pp_pkg.sv
package pp_pkg;
  // Strobes passed from the control module to the datapath
  typedef struct packed {
    logic hostWrHit;  // host write aimed at an implemented channel
    logic hostRdEn;   // port B read requested this cycle
    logic rdHitQ;     // registered: last read hit an implemented channel
  } ppStrobes_t;
endpackage

// File: rtl/pp_control.sv
module pp_control
  import pp_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int DEPTH    = 128,
  parameter int CH_SEL_W = 3,
  parameter int IDX_W    = $clog2(DEPTH),
  localparam int ADDR_W  = CH_SEL_W + IDX_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   hostAddr,
  input  logic                hostWr,
  input  logic                hostRd,
  output logic [IDX_W-1:0]    playAddr,
  output logic [IDX_W-1:0]    playIndex,
  output logic [CH_SEL_W-1:0] hostCh,
  output logic [IDX_W-1:0]    hostWord,
  output logic [CH_SEL_W-1:0] rdChQ,
  output ppStrobes_t          st,
  output logic                hostRdValid
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic chImpl;
  logic rdHitQ;

  always_comb begin
    hostCh   = hostAddr[ADDR_W-1:IDX_W];
    hostWord = hostAddr[IDX_W-1:0];
    chImpl   = (int'(hostCh) < NUM_CH);
    st.hostWrHit = hostWr && chImpl;
    st.hostRdEn  = hostRd;
    st.rdHitQ    = rdHitQ;
  end

  // Free-running shared sequencer; playIndex tags the registered output
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      playAddr  <= '0;
      playIndex <= '0;
    end else begin
      playAddr  <= (playAddr == LAST_IDX) ? '0 : playAddr + 1'b1;
      playIndex <= playAddr;
    end
  end

  // Host read pipeline tracking
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdHitQ      <= 1'b0;
      rdChQ       <= '0;
      hostRdValid <= 1'b0;
    end else begin
      rdHitQ      <= hostRd && chImpl;
      rdChQ       <= hostCh;
      hostRdValid <= hostRd;
    end
  end
endmodule

// File: rtl/pp_datapath.sv
module pp_datapath
  import pp_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int DEPTH    = 128,
  parameter int WORD_W   = 28,
  parameter int NARROW_W = 21,
  parameter int CH_SEL_W = 3,
  parameter int IDX_W    = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     narrowMode,
  input  ppStrobes_t               st,
  input  logic [IDX_W-1:0]         playAddr,
  input  logic [CH_SEL_W-1:0]      hostCh,
  input  logic [IDX_W-1:0]         hostWord,
  input  logic [CH_SEL_W-1:0]      rdChQ,
  input  logic [WORD_W-1:0]        hostWrData,
  output logic [NUM_CH*WORD_W-1:0] chanData,
  output logic [WORD_W-1:0]        hostRdData
);
  localparam logic [WORD_W-1:0] NARROW_MASK =
    {{(WORD_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [WORD_W-1:0] playWord [NUM_CH];
  logic [WORD_W-1:0] portBWord [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    logic [WORD_W-1:0] mem [DEPTH];

    // Port B: host write and readback
    always_ff @(posedge clk) begin
      if (st.hostWrHit && hostCh == CH_SEL_W'(g))
        mem[hostWord] <= hostWrData;
      if (st.hostRdEn)
        portBWord[g] <= mem[hostWord];
    end

    // Port A: playback read, zero until the first read after reset
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) playWord[g] <= '0;
      else        playWord[g] <= mem[playAddr];
    end

    assign chanData[g*WORD_W +: WORD_W] =
      narrowMode ? (playWord[g] & NARROW_MASK) : playWord[g];
  end

  always_comb begin
    hostRdData = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (st.rdHitQ && rdChQ == CH_SEL_W'(c)) hostRdData = portBWord[c];
  end
endmodule

// File: rtl/pattern_player.sv
module pattern_player
  import pp_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int DEPTH    = 128,
  parameter int WORD_W   = 28,
  parameter int NARROW_W = 21,
  parameter int CH_SEL_W = 3,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int ADDR_W  = CH_SEL_W + IDX_W
) (
  input  logic                     clkLocal,
  input  logic                     clkExt,
  input  logic                     clkSel,
  input  logic                     rst_n,
  input  logic                     narrowMode,
  input  logic [ADDR_W-1:0]        hostAddr,
  input  logic [WORD_W-1:0]        hostWrData,
  input  logic                     hostWr,
  input  logic                     hostRd,
  output logic [WORD_W-1:0]        hostRdData,
  output logic                     hostRdValid,
  output logic [NUM_CH*WORD_W-1:0] chanData,
  output logic [IDX_W-1:0]         playIndex
);
  logic                playClk;
  ppStrobes_t          st;
  logic [IDX_W-1:0]    playAddr;
  logic [CH_SEL_W-1:0] hostCh;
  logic [IDX_W-1:0]    hostWord;
  logic [CH_SEL_W-1:0] rdChQ;

  // Static source select; only switched while reset is asserted
  always_comb playClk = clkSel ? clkExt : clkLocal;

  pp_control #(
    .NUM_CH(NUM_CH), .DEPTH(DEPTH), .CH_SEL_W(CH_SEL_W), .IDX_W(IDX_W)
  ) uCtrl (
    .clk(playClk), .rst_n(rst_n), .hostAddr(hostAddr), .hostWr(hostWr),
    .hostRd(hostRd), .playAddr(playAddr), .playIndex(playIndex),
    .hostCh(hostCh), .hostWord(hostWord), .rdChQ(rdChQ), .st(st),
    .hostRdValid(hostRdValid)
  );

  pp_datapath #(
    .NUM_CH(NUM_CH), .DEPTH(DEPTH), .WORD_W(WORD_W), .NARROW_W(NARROW_W),
    .CH_SEL_W(CH_SEL_W), .IDX_W(IDX_W)
  ) uData (
    .clk(playClk), .rst_n(rst_n), .narrowMode(narrowMode), .st(st),
    .playAddr(playAddr), .hostCh(hostCh), .hostWord(hostWord),
    .rdChQ(rdChQ), .hostWrData(hostWrData), .chanData(chanData),
    .hostRdData(hostRdData)
  );
endmodule

// File: rtl/pp_checker.sv
module pp_checker #(
  parameter int NUM_CH   = 4,
  parameter int DEPTH    = 128,
  parameter int WORD_W   = 28,
  parameter int NARROW_W = 21,
  parameter int CH_SEL_W = 3,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int ADDR_W  = CH_SEL_W + IDX_W
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     narrowMode,
  input logic [ADDR_W-1:0]        hostAddr,
  input logic                     hostRd,
  input logic [WORD_W-1:0]        hostRdData,
  input logic                     hostRdValid,
  input logic [NUM_CH*WORD_W-1:0] chanData,
  input logic [IDX_W-1:0]         playIndex
);
  localparam logic [WORD_W-1:0] HIGH_MASK =
    {{(WORD_W-NARROW_W){1'b1}}, {NARROW_W{1'b0}}};
  localparam logic [NUM_CH*WORD_W-1:0] HIGH_ALL = {NUM_CH{HIGH_MASK}};
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic started;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  // R2
  index_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && playIndex != LAST_IDX) |=> playIndex == $past(playIndex) + 1'b1);

  // R2
  index_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && playIndex == LAST_IDX) |=> playIndex == '0);

  // R6
  reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> (chanData == '0 && playIndex == '0));

  // R7
  narrow_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    narrowMode |-> (chanData & HIGH_ALL) == '0);

  // R4
  read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hostRd |=> hostRdValid);

  // R4
  read_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hostRd |=> !hostRdValid);

  // R5
  unimpl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hostRd && int'(hostAddr[ADDR_W-1:IDX_W]) >= NUM_CH) |=> hostRdData == '0);
endmodule

bind pattern_player pp_checker #(
  .NUM_CH(NUM_CH), .DEPTH(DEPTH), .WORD_W(WORD_W), .NARROW_W(NARROW_W),
  .CH_SEL_W(CH_SEL_W)
) uChk (
  .clk(playClk), .rst_n(rst_n), .narrowMode(narrowMode), .hostAddr(hostAddr),
  .hostRd(hostRd), .hostRdData(hostRdData), .hostRdValid(hostRdValid),
  .chanData(chanData), .playIndex(playIndex)
);

// File: tb/sim_pattern_player.sv
module sim_pattern_player;
  localparam int NCH = 4;

  logic clkLocal = 0, clkExt = 0, clkSel = 0, rst_n = 0, narrowMode = 0;
  logic [9:0]  hostAddr = '0;
  logic [27:0] hostWrData = '0;
  logic        hostWr = 0, hostRd = 0;
  logic [27:0] hostRdData;
  logic        hostRdValid;
  logic [NCH*28-1:0] chanData;
  logic [6:0]  playIndex;

  logic localRun = 1, extRun = 1, useExt = 0, finished = 0;
  int checks = 0, errors = 0;
  int ovCh = -1, ovW = 0;
  logic [27:0] ovVal = '0;

  // 20-unit period: 50 MHz with 1 ns units; external clock at another rate
  always #10 clkLocal = localRun ? ~clkLocal : 1'b0;
  always #7  clkExt   = extRun   ? ~clkExt   : 1'b0;

  pattern_player u0 (
    .clkLocal(clkLocal), .clkExt(clkExt), .clkSel(clkSel), .rst_n(rst_n),
    .narrowMode(narrowMode), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .hostWr(hostWr), .hostRd(hostRd), .hostRdData(hostRdData),
    .hostRdValid(hostRdValid), .chanData(chanData), .playIndex(playIndex)
  );

  // Readback vectors {channel select, word index}
  localparam logic [9:0] RDV [8] = '{
    {3'd0, 7'd0}, {3'd1, 7'd127}, {3'd2, 7'd50}, {3'd3, 7'd64},
    {3'd4, 7'd10}, {3'd7, 7'd127}, {3'd3, 7'd1}, {3'd5, 7'd0}
  };

  function automatic logic [27:0] pat(int ch, int i);
    return 28'((ch * 32'h1F3A7 + i * 32'h9E37 + 32'h5A5) ^ (i << 21));
  endfunction

  function automatic logic [27:0] expv(int ch, int i);
    if (ch == ovCh && i == ovW) return ovVal;
    return pat(ch, i);
  endfunction

  function automatic logic [27:0] chw(int ch);
    return chanData[ch*28 +: 28];
  endfunction

  task automatic tick();
    if (useExt) @(negedge clkExt);
    else        @(negedge clkLocal);
  endtask

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic hostRead(logic [9:0] a, output logic [27:0] d, output logic v);
    hostAddr = a; hostRd = 1;
    tick();
    d = hostRdData; v = hostRdValid;
    hostRd = 0;
  endtask

  // Check every channel against the expected word at playIndex
  task automatic checkPlayback(int n, bit narrow, string req);
    int prev;
    prev = playIndex;
    for (int k = 0; k < n; k++) begin
      tick();
      chk(playIndex == 7'((prev + 1) % 128), "R2 index step", playIndex, 7'((prev + 1) % 128));
      for (int c = 0; c < NCH; c++) begin
        logic [27:0] e;
        e = expv(c, playIndex);
        if (narrow) e = e & 28'h01FFFFF;
        chk(chw(c) == e, req, chw(c), e);
      end
      prev = playIndex;
    end
  endtask

  initial begin
    logic [27:0] d;
    logic v;
    int prev;
    bit stepOk;

    // Reset state
    repeat (3) tick();
    chk(chanData == '0, "R6 outputs zero in reset", 32'(chanData[31:0]), 0);
    chk(playIndex == 0, "R6 index zero in reset", playIndex, 0);
    chk(hostRdValid == 0, "R4 no valid in reset", hostRdValid, 0);

    // Load all tables while playing; sequencer must keep stepping (R9)
    rst_n = 1;
    tick();
    prev = playIndex;
    stepOk = 1;
    for (int c = 0; c < NCH; c++)
      for (int i = 0; i < 128; i++) begin
        hostWr = 1; hostAddr = {3'(c), 7'(i)}; hostWrData = pat(c, i);
        tick();
        if (playIndex != 7'((prev + 1) % 128)) stepOk = 0;
        prev = playIndex;
      end
    hostWr = 0;
    chk(stepOk, "R9 playback steps during host writes", stepOk, 1);

    // Second reset: first-edge behaviour
    rst_n = 0;
    repeat (2) tick();
    chk(chanData == '0 && playIndex == 0, "R6 reset clears outputs", playIndex, 0);
    rst_n = 1;
    chk(chanData == '0, "R6 zero before first edge", 32'(chanData[31:0]), 0);
    tick();
    chk(playIndex == 0, "R6 first edge shows index 0", playIndex, 0);
    for (int c = 0; c < NCH; c++)
      chk(chw(c) == pat(c, 0), "R6 first edge word 0", chw(c), pat(c, 0));

    // Full passes including the wrap: content and lockstep (R1, R2, R3)
    checkPlayback(300, 0, "R3 R1 lockstep channel word");

    // Write during playback; effect on a later pass (R1, R9)
    ovCh = 2; ovW = 50; ovVal = 28'hC0FFEE5;
    hostWr = 1; hostAddr = {3'd2, 7'd50}; hostWrData = ovVal;
    tick();
    hostWr = 0;
    for (int k = 0; k < 260; k++) begin
      tick();
      if (playIndex == 50) break;
    end
    chk(playIndex == 50, "R1 reached updated index", playIndex, 50);
    chk(chw(2) == ovVal, "R1 updated word on channel 2", chw(2), ovVal);
    chk(chw(1) == pat(1, 50), "R3 other channel unchanged", chw(1), pat(1, 50));

    // Readback table (R4, R5)
    for (int k = 0; k < 8; k++) begin
      logic [27:0] e;
      e = (RDV[k][9:7] >= 3'd4) ? 28'h0 : expv(int'(RDV[k][9:7]), int'(RDV[k][6:0]));
      hostRead(RDV[k], d, v);
      chk(v == 1, "R4 read valid", v, 1);
      chk(d == e, (e == 0) ? "R5 unimplemented read zero" : "R4 readback word", d, e);
    end
    tick();
    chk(hostRdValid == 0, "R4 valid drops without read", hostRdValid, 0);

    // Write to unimplemented channel is ignored (R5)
    hostWr = 1; hostAddr = {3'd5, 7'd10}; hostWrData = 28'hABCDEF1;
    tick();
    hostWr = 0;
    hostRead({3'd5, 7'd10}, d, v);
    chk(d == 0, "R5 unimplemented stays zero", d, 0);
    hostRead({3'd1, 7'd10}, d, v);
    chk(d == pat(1, 10), "R5 no alias into channel 1", d, pat(1, 10));
    checkPlayback(130, 0, "R5 tables intact after ignored write");

    // Narrow mode (R7)
    narrowMode = 1;
    checkPlayback(40, 1, "R7 narrow low bits only");
    hostRead({3'd0, 7'd127}, d, v);
    chk(d == pat(0, 127), "R7 readback full width", d, pat(0, 127));
    narrowMode = 0;

    // External clock with local clock stopped (R8)
    rst_n = 0;
    tick();
    clkSel = 1; useExt = 1;
    localRun = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk(playIndex == 0 && chw(3) == pat(3, 0), "R8 external clock first word", chw(3), pat(3, 0));
    checkPlayback(140, 0, "R8 playback from external clock");

    finishRun();
  end

  initial begin
    #4000000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end
endmodule